// File: doc/BRIEF.md
# DRAM Cycle Sequencer with CAS-Before-RAS Refresh

This block drives the strobes of a DRAM array that sits on the upper half of a 32-bit processor's address space. It turns a processor memory request into a DRAM access and acknowledges it. It also fits in periodic refresh. A free-running interval timer fires once per refresh period and sets a pending-request flag. While that flag is set, no new processor access may begin. As soon as the sequencer is idle, it runs a refresh in which the column strobe falls before the row strobe. The DRAM keeps its own refresh row pointer, so the block never drives a refresh row and has no address counter.

A processor access that is already under way always finishes first. A processor request that arrives while refresh is pending waits with its strobe held. It is then served once the refresh and the precharge that follows it are over. The processor does not have to strobe again.

The sequencer has eight states. IDLE moves to RF_CAS when a refresh is pending, or to ROW when a DRAM request is present. The processor path runs ROW, COL, CAS and ACK, then PRECH. The refresh path runs RF_CAS, RF_RAS and then PRECH. PRECH returns to IDLE once the precharge count has run out.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is held (rst_n low), dram_ras_n, dram_cas_n and dram_we_n are 1, dram_col_sel is 0 and cpu_ack is 0.
- R2: A DRAM access starts only when cpu_as_n is 0 and cpu_a31 is 1. With cpu_a31 at 0, dram_ras_n stays 1 and cpu_ack stays 0 for as long as the strobe is held.
- R3: A processor access taken from idle proceeds one clock at a time: dram_ras_n goes low with dram_col_sel 0 (row) in the first clock after the request is sampled. In the second clock dram_col_sel is 1 (column) while dram_cas_n is still 1. From the third clock dram_cas_n is 0 for CAS_CYCLES clocks. Then cpu_ack is 1 for one clock. cpu_ack is therefore first seen 3+CAS_CYCLES clocks after the request is sampled, and dram_ras_n and dram_cas_n rise together in the next clock.
- R4: While dram_ras_n is low in a processor access, dram_we_n is 0 for a write (cpu_rw 0) and 1 for a read (cpu_rw 1). cpu_rw is captured when the access starts.
- R5: A refresh drives dram_cas_n low with dram_ras_n high for one clock. Both strobes are then low for RF_RAS_CYCLES clocks, and then both rise together. Throughout the refresh, dram_we_n is 1, dram_col_sel is 0 and cpu_ack is 0.
- R6: The interval timer raises a refresh request every REFRESH_CYCLES clocks from reset, reloading as it fires. With the bus idle, successive refreshes begin exactly REFRESH_CYCLES clocks apart.
- R7: If a refresh is pending when the sequencer is idle, the refresh starts before any waiting processor request. The waiting request is then served without a new strobe, and its cpu_ack appears 1+RF_RAS_CYCLES+PRECHARGE_CYCLES+1+3+CAS_CYCLES clocks after the request was sampled.
- R8: A refresh request that arrives during a processor access does not shorten that access: cpu_ack still comes after 3+CAS_CYCLES clocks. The refresh then starts PRECHARGE_CYCLES+2 clocks after the cpu_ack clock.
- R9: After any access or refresh, dram_ras_n and dram_cas_n both stay high for at least PRECHARGE_CYCLES clocks before either falls again. Back to back, this gap is PRECHARGE_CYCLES+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_as_n | input | 1 | Processor address strobe, active low, held until acknowledged |
| cpu_a31 | input | 1 | Address bit 31; 1 selects the DRAM |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_col_sel | output | 1 | Address mux select: 0 row, 1 column |
| cpu_ack | output | 1 | One-clock cycle acknowledge to the processor |

## Verification
The hardest situations to reach are the two collisions between the timer and a processor request. In one, a request and the freshly latched refresh meet at an idle sequencer on the same clock. In the other, the timer fires while an access is in its column phase. The timer state is not visible at the ports. The bench therefore locks onto the period by watching the column strobe fall while the row strobe is high, which only a refresh does. It then counts whole periods forward and raises the strobe one clock or three clocks before the next refresh is due. That produces each collision on an exact clock, and the acknowledge and refresh start times can be predicted to the clock.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CAS,
        ST_ACK,
        ST_RF_CAS,
        ST_RF_RAS,
        ST_PRECH
    } seq_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
    parameter int INTERVAL = 3900
) (
    input  logic clk,
    input  logic rst_n,
    output logic expire
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(INTERVAL - 1);

    logic [TW-1:0] cnt_q;

    assign expire = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD;
        end else if (expire) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dref_req_latch.sv
module dref_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clear_req,
    output logic pending
);
    // A new expiry outranks a clear that lands on the same clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (set_req) begin
            pending <= 1'b1;
        end else if (clear_req) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/dref_dwell_counter.sv
module dref_dwell_counter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign done = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dref_seq_fsm.sv
module dref_seq_fsm
    import dref_pkg::*;
#(
    parameter int CAS_CYCLES       = 2,
    parameter int RF_RAS_CYCLES    = 3,
    parameter int PRECHARGE_CYCLES = 3,
    parameter int DW               = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_as_n,
    input  logic          cpu_a31,
    input  logic          cpu_rw,
    input  logic          refresh_pending,
    input  logic          dwell_done,
    output logic          dwell_load,
    output logic [DW-1:0] dwell_val,
    output logic          refresh_done,
    output logic          seq_idle,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          col_sel,
    output logic          ack
);
    localparam logic [DW-1:0] CAS_LOAD = DW'(CAS_CYCLES - 1);
    localparam logic [DW-1:0] RFR_LOAD = DW'(RF_RAS_CYCLES - 1);
    localparam logic [DW-1:0] PRE_LOAD = DW'(PRECHARGE_CYCLES - 1);

    seq_state_t state_q, state_d;
    logic       is_write_q;
    logic       start_cpu;
    logic       dram_req;

    assign dram_req = !cpu_as_n && cpu_a31;
    assign seq_idle = (state_q == ST_IDLE);

    // State register, plus the direction captured at access start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            is_write_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_cpu) begin
                is_write_q <= !cpu_rw;
            end
        end
    end

    // Next state and dwell loads.
    always_comb begin
        state_d      = state_q;
        dwell_load   = 1'b0;
        dwell_val    = '0;
        refresh_done = 1'b0;
        start_cpu    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (refresh_pending) begin
                    state_d    = ST_RF_CAS;
                    dwell_load = 1'b1;
                end else if (dram_req) begin
                    state_d    = ST_ROW;
                    dwell_load = 1'b1;
                    start_cpu  = 1'b1;
                end
            end
            ST_ROW: begin
                state_d = ST_COL;
            end
            ST_COL: begin
                state_d    = ST_CAS;
                dwell_load = 1'b1;
                dwell_val  = CAS_LOAD;
            end
            ST_CAS: begin
                if (dwell_done) begin
                    state_d = ST_ACK;
                end
            end
            ST_ACK: begin
                state_d    = ST_PRECH;
                dwell_load = 1'b1;
                dwell_val  = PRE_LOAD;
            end
            ST_RF_CAS: begin
                state_d    = ST_RF_RAS;
                dwell_load = 1'b1;
                dwell_val  = RFR_LOAD;
            end
            ST_RF_RAS: begin
                if (dwell_done) begin
                    state_d      = ST_PRECH;
                    dwell_load   = 1'b1;
                    dwell_val    = PRE_LOAD;
                    refresh_done = 1'b1;
                end
            end
            ST_PRECH: begin
                if (dwell_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Moore outputs.
    always_comb begin
        ras_n   = 1'b1;
        cas_n   = 1'b1;
        we_n    = 1'b1;
        col_sel = 1'b0;
        ack     = 1'b0;
        unique case (state_q)
            ST_ROW: begin
                ras_n = 1'b0;
                we_n  = !is_write_q;
            end
            ST_COL: begin
                ras_n   = 1'b0;
                col_sel = 1'b1;
                we_n    = !is_write_q;
            end
            ST_CAS: begin
                ras_n   = 1'b0;
                cas_n   = 1'b0;
                col_sel = 1'b1;
                we_n    = !is_write_q;
            end
            ST_ACK: begin
                ras_n   = 1'b0;
                cas_n   = 1'b0;
                col_sel = 1'b1;
                we_n    = !is_write_q;
                ack     = 1'b1;
            end
            ST_RF_CAS: begin
                cas_n = 1'b0;
            end
            ST_RF_RAS: begin
                cas_n = 1'b0;
                ras_n = 1'b0;
            end
            ST_IDLE, ST_PRECH: begin
                ras_n = 1'b1;
            end
            default: begin
                ras_n = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer
    import dref_pkg::*;
#(
    parameter int REFRESH_CYCLES   = 3900,
    parameter int CAS_CYCLES       = 2,
    parameter int RF_RAS_CYCLES    = 3,
    parameter int PRECHARGE_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_as_n,
    input  logic cpu_a31,
    input  logic cpu_rw,
    output logic dram_ras_n,
    output logic dram_cas_n,
    output logic dram_we_n,
    output logic dram_col_sel,
    output logic cpu_ack
);
    localparam int DWELL_MAX = max3(CAS_CYCLES, RF_RAS_CYCLES, PRECHARGE_CYCLES);
    localparam int DWELL_W   = $clog2(DWELL_MAX + 1);

    logic               timer_expire;
    logic               refresh_pending;
    logic               refresh_done;
    logic               seq_idle;
    logic               dwell_load;
    logic [DWELL_W-1:0] dwell_val;
    logic               dwell_done;

    dref_interval_timer #(
        .INTERVAL(REFRESH_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (timer_expire)
    );

    dref_req_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (timer_expire),
        .clear_req (refresh_done),
        .pending   (refresh_pending)
    );

    dref_dwell_counter #(
        .W(DWELL_W)
    ) u_dwell (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dwell_load),
        .load_val (dwell_val),
        .done     (dwell_done)
    );

    dref_seq_fsm #(
        .CAS_CYCLES       (CAS_CYCLES),
        .RF_RAS_CYCLES    (RF_RAS_CYCLES),
        .PRECHARGE_CYCLES (PRECHARGE_CYCLES),
        .DW               (DWELL_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .cpu_as_n        (cpu_as_n),
        .cpu_a31         (cpu_a31),
        .cpu_rw          (cpu_rw),
        .refresh_pending (refresh_pending),
        .dwell_done      (dwell_done),
        .dwell_load      (dwell_load),
        .dwell_val       (dwell_val),
        .refresh_done    (refresh_done),
        .seq_idle        (seq_idle),
        .ras_n           (dram_ras_n),
        .cas_n           (dram_cas_n),
        .we_n            (dram_we_n),
        .col_sel         (dram_col_sel),
        .ack             (cpu_ack)
    );
endmodule

// File: rtl/dref_checker.sv
module dref_checker #(
    parameter int PRECHARGE_CYCLES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cpu_as_n,
    input logic cpu_a31,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n,
    input logic dram_col_sel,
    input logic cpu_ack,
    input logic refresh_pending,
    input logic seq_idle
);
    localparam int HW = $clog2(PRECHARGE_CYCLES + 2);
    localparam logic [HW-1:0] PRE = HW'(PRECHARGE_CYCLES);

    logic [HW-1:0] hi_cnt;

    // Consecutive clocks with both strobes high; reset counts as precharged.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= PRE;
        end else if (dram_ras_n && dram_cas_n) begin
            if (hi_cnt < PRE) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
        end else begin
            hi_cnt <= '0;
        end
    end

    p_dram_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && dram_cas_n) |-> $past(!cpu_as_n && cpu_a31));

    p_ack_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> (!dram_ras_n && !dram_cas_n && dram_col_sel));

    p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    p_cas_after_mux_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_ras_n) |-> $past(dram_col_sel));

    p_joint_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> $rose(dram_cas_n));

    p_cbr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> $past(!dram_cas_n));

    p_refresh_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && dram_ras_n) |-> (dram_we_n && !cpu_ack && !dram_col_sel));

    p_refresh_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_pending && seq_idle) |=> (!dram_cas_n && dram_ras_n));

    p_precharge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(dram_ras_n) && dram_cas_n) || ($fell(dram_cas_n) && dram_ras_n))
            |-> (hi_cnt >= PRE));
endmodule

bind dram_refresh_sequencer dref_checker #(
    .PRECHARGE_CYCLES(PRECHARGE_CYCLES)
) u_dref_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_as_n        (cpu_as_n),
    .cpu_a31         (cpu_a31),
    .dram_ras_n      (dram_ras_n),
    .dram_cas_n      (dram_cas_n),
    .dram_we_n       (dram_we_n),
    .dram_col_sel    (dram_col_sel),
    .cpu_ack         (cpu_ack),
    .refresh_pending (refresh_pending),
    .seq_idle        (seq_idle)
);

// File: tb/tb_dram_refresh_sequencer.sv
module tb_dram_refresh_sequencer;
    localparam int RF  = 100;
    localparam int CAS = 2;
    localparam int RFR = 3;
    localparam int PRE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_as_n = 1'b1;
    logic cpu_a31 = 1'b0;
    logic cpu_rw = 1'b1;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_col_sel, cpu_ack;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;
    int last_rf_start = -1;
    bit prev_in_rf = 1'b0;

    // Results of the most recent access.
    int lat, first_ras, first_col, first_cas, we_bad, ack_tick, first_ras_abs;
    bit got_ack, row_ok, colcas_ok;

    always #2 clk = ~clk;

    dram_refresh_sequencer #(
        .REFRESH_CYCLES   (RF),
        .CAS_CYCLES       (CAS),
        .RF_RAS_CYCLES    (RFR),
        .PRECHARGE_CYCLES (PRE)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_as_n     (cpu_as_n),
        .cpu_a31      (cpu_a31),
        .cpu_rw       (cpu_rw),
        .dram_ras_n   (dram_ras_n),
        .dram_cas_n   (dram_cas_n),
        .dram_we_n    (dram_we_n),
        .dram_col_sel (dram_col_sel),
        .cpu_ack      (cpu_ack)
    );

    // Clock counter and refresh-start detector (column low with row high).
    always @(negedge clk) begin
        ncyc = ncyc + 1;
        if (!dram_cas_n && dram_ras_n && !prev_in_rf) last_rf_start = ncyc;
        prev_in_rf = !dram_cas_n && dram_ras_n;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic cpu_access(input bit a31, input bit rw, input int max_lat);
        lat = 0; first_ras = -1; first_col = -1; first_cas = -1; we_bad = 0;
        got_ack = 0; row_ok = 0; colcas_ok = 0; first_ras_abs = -1;
        cpu_a31 = a31; cpu_rw = rw; cpu_as_n = 1'b0;
        while (!got_ack && lat < max_lat) begin
            tick();
            lat++;
            if (!dram_ras_n && first_ras < 0) begin
                first_ras = lat; first_ras_abs = ncyc; row_ok = !dram_col_sel;
            end
            if (dram_col_sel && first_col < 0) begin
                first_col = lat; colcas_ok = dram_cas_n;
            end
            if (!dram_cas_n && first_cas < 0) first_cas = lat;
            if (!dram_ras_n && dram_we_n != rw) we_bad++;
            if (cpu_ack) begin
                got_ack = 1; ack_tick = ncyc;
            end
        end
        cpu_as_n = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) tick();
        check(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes high in reset",
              {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        check(!dram_col_sel && !cpu_ack, "R1", "mux/ack low in reset",
              {dram_col_sel, cpu_ack}, 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_read_basic();
        cpu_access(1'b1, 1'b1, 20);
        check(got_ack && lat == 3 + CAS, "R3", "read ack latency", lat, 3 + CAS);
        check(first_ras == 1 && row_ok, "R3", "row phase first", first_ras, 1);
        check(first_col == 2 && colcas_ok, "R3", "column mux before CAS", first_col, 2);
        check(first_cas == 3, "R3", "CAS fall clock", first_cas, 3);
        check(we_bad == 0, "R4", "we_n high during read", we_bad, 0);
        tick();
        check(dram_ras_n && dram_cas_n, "R3", "strobes rise together",
              {dram_ras_n, dram_cas_n}, 3);
    endtask

    task automatic t_write_b2b();
        int prev_ack;
        cpu_access(1'b1, 1'b0, 20);
        prev_ack = ack_tick;
        check(got_ack && we_bad == 0, "R4", "we_n low during first write", we_bad, 0);
        cpu_access(1'b1, 1'b0, 30);
        check(got_ack && lat == PRE + 1 + 3 + CAS, "R9", "back-to-back latency",
              lat, PRE + 1 + 3 + CAS);
        check(first_ras_abs - prev_ack - 1 == PRE + 1, "R9", "precharge gap",
              first_ras_abs - prev_ack - 1, PRE + 1);
        check(we_bad == 0, "R4", "we_n low during second write", we_bad, 0);
        repeat (PRE + 1) tick();
    endtask

    task automatic t_a31_low();
        int ras_lows = 0;
        int acks = 0;
        cpu_a31 = 1'b0; cpu_rw = 1'b1; cpu_as_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (!dram_ras_n) ras_lows++;
            if (cpu_ack) acks++;
        end
        cpu_as_n = 1'b1;
        check(ras_lows == 0, "R2", "no RAS with a31=0", ras_lows, 0);
        check(acks == 0, "R2", "no ack with a31=0", acks, 0);
    endtask

    task automatic wait_rf();
        int old;
        old = last_rf_start;
        while (last_rf_start == old) tick();
    endtask

    task automatic t_refresh_and_interval(output int start_b);
        int start_a;
        int bad = 0;
        wait_rf();
        start_a = last_rf_start;
        check(dram_ras_n && dram_we_n && !dram_col_sel && !cpu_ack, "R5",
              "CAS-only first refresh clock", {dram_ras_n, dram_we_n, dram_col_sel, cpu_ack}, 12);
        for (int i = 0; i < RFR; i++) begin
            tick();
            if (dram_ras_n || dram_cas_n || !dram_we_n || cpu_ack || dram_col_sel) bad++;
        end
        check(bad == 0, "R5", "both strobes low, we_n high, no ack", bad, 0);
        tick();
        check(dram_ras_n && dram_cas_n, "R5", "refresh strobes released",
              {dram_ras_n, dram_cas_n}, 3);
        wait_rf();
        start_b = last_rf_start;
        check(start_b - start_a == RF, "R6", "refresh interval", start_b - start_a, RF);
    endtask

    task automatic t_holdoff(input int start_b);
        while (ncyc < start_b + RF - 1) tick();
        cpu_access(1'b1, 1'b1, 40);
        check(last_rf_start == start_b + RF, "R7", "refresh started first",
              last_rf_start, start_b + RF);
        check(got_ack && lat == 1 + RFR + PRE + 1 + 3 + CAS, "R7", "held request latency",
              lat, 1 + RFR + PRE + 1 + 3 + CAS);
        check(we_bad == 0, "R4", "we_n high for held read", we_bad, 0);
    endtask

    task automatic t_inflight(input int start_b);
        while (ncyc < start_b + 2 * RF - 3) tick();
        cpu_access(1'b1, 1'b1, 20);
        check(got_ack && lat == 3 + CAS, "R8", "in-flight access not cut", lat, 3 + CAS);
        while (ncyc < ack_tick + PRE + 4) tick();
        check(last_rf_start == ack_tick + PRE + 2, "R8", "deferred refresh start",
              last_rf_start, ack_tick + PRE + 2);
    endtask

    initial begin
        int sb;
        t_reset();
        t_read_basic();
        t_write_b2b();
        t_a31_low();
        t_refresh_and_interval(sb);
        t_holdoff(sb);
        t_inflight(sb);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", ncyc, 0);
        summary();
        $finish;
    end
endmodule